// File: doc/BRIEF.md
# Disk Geometry Bisection Prober

This block finds the head, cylinder and sector counts of an attached disk drive when no geometry table is available. It works only by trial: it asks a command engine to seek to a chosen address, and from whether each seek succeeds it narrows each dimension by halving. Each dimension has its own search interval. The block tries the midpoint of that interval, keeps the upper half if the seek succeeds and the lower half if it fails, and stops when the interval holds a single value.

The prober is started with a one-cycle pulse and a drive number. It handles heads first, then cylinders, then sectors. Every seek request carries all three address fields. The dimension being probed carries its midpoint. A dimension already probed carries its final value. A dimension not yet reached carries zero. Only one seek is in flight at a time. When the last dimension is settled, a one-cycle strobe presents the discovered counts, each being the highest address that passed plus one.

Top module: `geom_bisect_prober`

## Requirements
- R1: The dimensions are probed strictly in the order heads, cylinders, sectors; no seek for a later dimension is issued before the earlier one is settled.
- R2: On every start the search interval of each dimension is reset to a lower bound of 0 and an exclusive upper bound of 16 (heads), 1024 (cylinders) or 64 (sectors). The first seek of a run therefore carries head 8, cylinder 0, sector 0.
- R3: The probed value of the active dimension is floor((lower + upper) / 2).
- R4: A completion with seek_err_i = 0 (pass) raises the lower bound to the probed value. A completion with seek_err_i = 1 (fail) lowers the upper bound to the probed value.
- R5: A dimension is settled when lower = upper - 1. From then on its field carries the lower bound on every later seek of the run.
- R6: The field of a dimension not yet probed is 0 on every seek. The head field is 5 bits wide, the cylinder field 10 bits and the sector field 6 bits.
- R7: When all three dimensions are settled, geom_valid_o is high for exactly one cycle, busy_o is low in that cycle, and each count output equals that dimension's final lower bound plus one. Head, cylinder and sector counts are 5, 11 and 7 bits wide.
- R8: At most one seek is outstanding. seek_req_o is a one-cycle pulse. The next pulse comes only after seek_done_i has been seen, and the address and drive fields hold steady while a seek is outstanding.
- R9: A start pulse that arrives while busy_o is high is ignored: the running sequence, its drive number and its result are unchanged, and no extra run follows.
- R10: The drive number present with an accepted start is captured and carried on seek_drive_o for every seek of that run.
- R11: busy_o is high from the cycle after an accepted start until the cycle in which geom_valid_o pulses.
- R12: After reset the block is idle: busy_o, seek_req_o and geom_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin probing |
| drive_i | input | 3 | Drive number to probe, sampled with an accepted start |
| seek_req_o | output | 1 | One-cycle pulse issuing a seek |
| seek_drive_o | output | 3 | Drive number of the seek |
| seek_head_o | output | 5 | Head address of the seek |
| seek_cyl_o | output | 10 | Cylinder address of the seek |
| seek_sect_o | output | 6 | Sector address of the seek |
| seek_done_i | input | 1 | Completion of the outstanding seek |
| seek_err_i | input | 1 | Valid with seek_done_i: 1 = seek failed, 0 = seek passed |
| busy_o | output | 1 | A probing run is in progress |
| geom_valid_o | output | 1 | One-cycle strobe: geometry outputs are final |
| geom_heads_o | output | 5 | Discovered head count |
| geom_cyls_o | output | 11 | Discovered cylinder count |
| geom_sects_o | output | 7 | Discovered sector count |

## Verification
The bench models a drive that rejects any seek whose head, cylinder or sector lies beyond its geometry. It predicts the exact list of seek addresses and the final counts for several drives. A mid-range drive with uneven counts mixes passes and fails in every dimension. A full-size drive makes every seek pass and so reaches the top of every interval. A one-head, one-cylinder, one-sector drive makes every seek fail and so reaches the bottom. A further run injects a second start with a different drive number partway through, which separates an ignored start from a restart or a drive change. The runs use completion latencies from zero to several cycles, including back-to-back runs, so a request issued before its completion, or fields that move while a seek is outstanding, show up as a seek that does not match the prediction.

// File: rtl/geom_probe_pkg.sv
package geom_probe_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bisect_dim.sv
module bisect_dim #(
    parameter int W     = 5,
    parameter int LIMIT = 16,
    localparam int BW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          active_i,
    input  logic          upd_i,
    input  logic          pass_i,
    output logic [W-1:0]  field_o,
    output logic          finished_o,
    output logic [BW-1:0] count_o
);

    typedef struct packed {
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
    } bounds_t;

    bounds_t       b_d, b_q;
    logic [BW-1:0] mid;

    // floor((lo+hi)/2) written without a carry bit; hi > lo always
    always_comb begin
        mid = b_q.lo + ((b_q.hi - b_q.lo) >> 1);
        b_d = b_q;
        if (clear_i) begin
            b_d.lo = '0;
            b_d.hi = BW'(LIMIT);
        end else if (upd_i) begin
            if (pass_i) b_d.lo = mid;
            else        b_d.hi = mid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.lo <= '0;
            b_q.hi <= BW'(LIMIT);
        end else begin
            b_q <= b_d;
        end
    end

    // unprobed dimensions sit at lo = 0, settled ones at their final lo
    assign field_o    = active_i ? mid[W-1:0] : b_q.lo[W-1:0];
    assign finished_o = ((b_q.lo + 1'b1) == b_q.hi);
    assign count_o    = b_q.lo + 1'b1;

endmodule

// File: rtl/probe_seq.sv
module probe_seq
    import geom_probe_pkg::*;
#(
    parameter int DRV_W = 3,
    parameter int NDIM  = 3,
    localparam int DIM_W = (NDIM > 1) ? $clog2(NDIM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DRV_W-1:0] drive_i,
    input  logic [NDIM-1:0]  fin_i,
    input  logic             seek_done_i,
    input  logic             seek_err_i,
    output logic             clear_o,
    output logic [NDIM-1:0]  active_o,
    output logic [NDIM-1:0]  upd_o,
    output logic             pass_o,
    output logic             seek_req_o,
    output logic [DRV_W-1:0] drive_o,
    output logic             busy_o,
    output logic             done_o
);

    typedef struct packed {
        seq_state_e       state;
        logic [DIM_W-1:0] dim;
        logic [DRV_W-1:0] drive;
        logic             req;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.req  = 1'b0;
        s_d.done = 1'b0;
        clear_o  = 1'b0;
        upd_o    = '0;
        pass_o   = !seek_err_i;
        unique case (s_q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    clear_o   = 1'b1;
                    s_d.drive = drive_i;
                    s_d.dim   = '0;
                    s_d.state = SQ_ISSUE;
                end
            end
            SQ_ISSUE: begin
                if (fin_i[s_q.dim]) begin
                    if (s_q.dim == DIM_W'(NDIM - 1)) begin
                        s_d.state = SQ_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.dim = s_q.dim + 1'b1;
                    end
                end else begin
                    s_d.req   = 1'b1;
                    s_d.state = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (seek_done_i) begin
                    upd_o[s_q.dim] = 1'b1;
                    s_d.state      = SQ_ISSUE;
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase
        for (int k = 0; k < NDIM; k++) begin
            active_o[k] = (s_q.state != SQ_IDLE) && (s_q.dim == DIM_W'(k));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= SQ_IDLE;
            s_q.dim   <= '0;
            s_q.drive <= '0;
            s_q.req   <= 1'b0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign seek_req_o = s_q.req;
    assign drive_o    = s_q.drive;
    assign busy_o     = (s_q.state != SQ_IDLE);
    assign done_o     = s_q.done;

endmodule

// File: rtl/geom_bisect_prober.sv
module geom_bisect_prober #(
    parameter int DRV_W    = 3,
    parameter int HEAD_W   = 5,
    parameter int CYL_W    = 10,
    parameter int SECT_W   = 6,
    parameter int HEAD_LIM = 16,
    parameter int CYL_LIM  = 1024,
    parameter int SECT_LIM = 64,
    localparam int HEAD_CW = $clog2(HEAD_LIM + 1),
    localparam int CYL_CW  = $clog2(CYL_LIM + 1),
    localparam int SECT_CW = $clog2(SECT_LIM + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [DRV_W-1:0]   drive_i,
    output logic               seek_req_o,
    output logic [DRV_W-1:0]   seek_drive_o,
    output logic [HEAD_W-1:0]  seek_head_o,
    output logic [CYL_W-1:0]   seek_cyl_o,
    output logic [SECT_W-1:0]  seek_sect_o,
    input  logic               seek_done_i,
    input  logic               seek_err_i,
    output logic               busy_o,
    output logic               geom_valid_o,
    output logic [HEAD_CW-1:0] geom_heads_o,
    output logic [CYL_CW-1:0]  geom_cyls_o,
    output logic [SECT_CW-1:0] geom_sects_o
);

    localparam int NDIM = 3;

    logic            clear;
    logic            pass;
    logic [NDIM-1:0] fin;
    logic [NDIM-1:0] active;
    logic [NDIM-1:0] upd;

    probe_seq #(
        .DRV_W (DRV_W),
        .NDIM  (NDIM)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .drive_i     (drive_i),
        .fin_i       (fin),
        .seek_done_i (seek_done_i),
        .seek_err_i  (seek_err_i),
        .clear_o     (clear),
        .active_o    (active),
        .upd_o       (upd),
        .pass_o      (pass),
        .seek_req_o  (seek_req_o),
        .drive_o     (seek_drive_o),
        .busy_o      (busy_o),
        .done_o      (geom_valid_o)
    );

    // index 0 = heads, 1 = cylinders, 2 = sectors: this is the probe order
    bisect_dim #(.W(HEAD_W), .LIMIT(HEAD_LIM)) u_heads (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .active_i   (active[0]),
        .upd_i      (upd[0]),
        .pass_i     (pass),
        .field_o    (seek_head_o),
        .finished_o (fin[0]),
        .count_o    (geom_heads_o)
    );

    bisect_dim #(.W(CYL_W), .LIMIT(CYL_LIM)) u_cyls (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .active_i   (active[1]),
        .upd_i      (upd[1]),
        .pass_i     (pass),
        .field_o    (seek_cyl_o),
        .finished_o (fin[1]),
        .count_o    (geom_cyls_o)
    );

    bisect_dim #(.W(SECT_W), .LIMIT(SECT_LIM)) u_sects (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .active_i   (active[2]),
        .upd_i      (upd[2]),
        .pass_i     (pass),
        .field_o    (seek_sect_o),
        .finished_o (fin[2]),
        .count_o    (geom_sects_o)
    );

endmodule

// File: rtl/geom_prober_checker.sv
module geom_prober_checker #(
    parameter int DRV_W    = 3,
    parameter int HEAD_W   = 5,
    parameter int CYL_W    = 10,
    parameter int SECT_W   = 6,
    parameter int HEAD_LIM = 16,
    parameter int CYL_LIM  = 1024,
    parameter int SECT_LIM = 64,
    localparam int HEAD_CW = $clog2(HEAD_LIM + 1),
    localparam int CYL_CW  = $clog2(CYL_LIM + 1),
    localparam int SECT_CW = $clog2(SECT_LIM + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               seek_req_o,
    input logic [DRV_W-1:0]   seek_drive_o,
    input logic [HEAD_W-1:0]  seek_head_o,
    input logic [CYL_W-1:0]   seek_cyl_o,
    input logic [SECT_W-1:0]  seek_sect_o,
    input logic               seek_done_i,
    input logic               busy_o,
    input logic               geom_valid_o,
    input logic [HEAD_CW-1:0] geom_heads_o,
    input logic [CYL_CW-1:0]  geom_cyls_o,
    input logic [SECT_CW-1:0] geom_sects_o
);

    logic outst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           outst_q <= 1'b0;
        else if (seek_req_o)  outst_q <= 1'b1;
        else if (seek_done_i) outst_q <= 1'b0;
    end

    a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        seek_req_o |-> !outst_q);

    a_r8_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> $stable({seek_drive_o, seek_head_o, seek_cyl_o, seek_sect_o}));

    a_r8_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        seek_req_o |-> busy_o);

    a_r2_fields_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        seek_req_o |-> (seek_head_o < HEAD_LIM) && (seek_cyl_o < CYL_LIM)
                       && (seek_sect_o < SECT_LIM));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        geom_valid_o |=> !geom_valid_o);

    a_r7_done_idle_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        geom_valid_o |-> !busy_o && (geom_heads_o != '0) && (geom_cyls_o != '0)
                         && (geom_sects_o != '0));

    a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r9_drive_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(seek_drive_o));

endmodule

bind geom_bisect_prober geom_prober_checker #(
    .DRV_W    (DRV_W),
    .HEAD_W   (HEAD_W),
    .CYL_W    (CYL_W),
    .SECT_W   (SECT_W),
    .HEAD_LIM (HEAD_LIM),
    .CYL_LIM  (CYL_LIM),
    .SECT_LIM (SECT_LIM)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .seek_req_o   (seek_req_o),
    .seek_drive_o (seek_drive_o),
    .seek_head_o  (seek_head_o),
    .seek_cyl_o   (seek_cyl_o),
    .seek_sect_o  (seek_sect_o),
    .seek_done_i  (seek_done_i),
    .busy_o       (busy_o),
    .geom_valid_o (geom_valid_o),
    .geom_heads_o (geom_heads_o),
    .geom_cyls_o  (geom_cyls_o),
    .geom_sects_o (geom_sects_o)
);

// File: tb/test_geom_bisect_prober.sv
`timescale 1ns/1ps
module test_geom_bisect_prober;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  drive_i = '0;
    logic        seek_req_o;
    logic [2:0]  seek_drive_o;
    logic [4:0]  seek_head_o;
    logic [9:0]  seek_cyl_o;
    logic [5:0]  seek_sect_o;
    logic        seek_done_i = 1'b0;
    logic        seek_err_i = 1'b0;
    logic        busy_o;
    logic        geom_valid_o;
    logic [4:0]  geom_heads_o;
    logic [10:0] geom_cyls_o;
    logic [6:0]  geom_sects_o;

    always #2.5 clk = ~clk;

    geom_bisect_prober i_geom_bisect_prober (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .drive_i      (drive_i),
        .seek_req_o   (seek_req_o),
        .seek_drive_o (seek_drive_o),
        .seek_head_o  (seek_head_o),
        .seek_cyl_o   (seek_cyl_o),
        .seek_sect_o  (seek_sect_o),
        .seek_done_i  (seek_done_i),
        .seek_err_i   (seek_err_i),
        .busy_o       (busy_o),
        .geom_valid_o (geom_valid_o),
        .geom_heads_o (geom_heads_o),
        .geom_cyls_o  (geom_cyls_o),
        .geom_sects_o (geom_sects_o)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    int q_h[$], q_c[$], q_s[$];
    int exp_drive, exp_h, exp_c, exp_s;
    int drv_h, drv_c, drv_s;
    int lat_g;
    int seek_idx;
    bit pend;
    int cnt;
    int ph, pc, ps;
    bit got_done;
    bit done_prev;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // behavioural bisection over the drive's accept rule
    task automatic build_expect(input int h, input int c, input int s);
        int lo[3];
        int hi[3];
        int t[3];
        lo = '{0, 0, 0};
        hi = '{16, 1024, 64};
        t  = '{0, 0, 0};
        q_h.delete(); q_c.delete(); q_s.delete();
        for (int d = 0; d < 3; d++) begin
            while (lo[d] != hi[d] - 1) begin
                t[d] = (lo[d] + hi[d]) / 2;
                q_h.push_back(t[0]); q_c.push_back(t[1]); q_s.push_back(t[2]);
                if (t[0] < h && t[1] < c && t[2] < s) lo[d] = t[d];
                else                                  hi[d] = t[d];
            end
            t[d] = lo[d];
        end
        exp_h = lo[0] + 1;
        exp_c = lo[1] + 1;
        exp_s = lo[2] + 1;
    endtask

    // drive model and per-cycle comparison, all at the falling edge
    initial begin
        pend = 1'b0;
        done_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                seek_done_i = 1'b0;
                seek_err_i  = 1'b0;
                if (seek_req_o)
                    check(!pend, "R8", "request while seek outstanding", 1, 0);
                if (pend) begin
                    check({seek_head_o, seek_cyl_o, seek_sect_o} == {5'(ph), 10'(pc), 6'(ps)},
                          "R8", "fields moved while outstanding",
                          {seek_head_o, seek_cyl_o, seek_sect_o}, {5'(ph), 10'(pc), 6'(ps)});
                    if (cnt == 0) begin
                        seek_done_i = 1'b1;
                        seek_err_i  = !(ph < drv_h && pc < drv_c && ps < drv_s);
                        pend = 1'b0;
                    end else begin
                        cnt--;
                    end
                end
                if (seek_req_o) begin
                    if (q_h.size() == 0) begin
                        check(1'b0, "R9", "unexpected seek", 1, 0);
                    end else begin
                        int eh, ec, es;
                        eh = q_h.pop_front(); ec = q_c.pop_front(); es = q_s.pop_front();
                        if (seek_idx == 0)
                            check(seek_head_o == 5'd8 && seek_cyl_o == 0 && seek_sect_o == 0,
                                  "R2", "first seek head", seek_head_o, 8);
                        check(seek_head_o == 5'(eh), "R1 R3 R4 R5", "seek head", seek_head_o, eh);
                        check(seek_cyl_o == 10'(ec), "R1 R3 R4 R5 R6", "seek cylinder", seek_cyl_o, ec);
                        check(seek_sect_o == 6'(es), "R1 R3 R4 R5 R6", "seek sector", seek_sect_o, es);
                        check(seek_drive_o == 3'(exp_drive), "R10", "seek drive",
                              seek_drive_o, exp_drive);
                    end
                    seek_idx++;
                    pend = 1'b1;
                    cnt  = lat_g + (seek_idx % 3);
                    ph = seek_head_o; pc = seek_cyl_o; ps = seek_sect_o;
                end
                if (done_prev)
                    check(!geom_valid_o, "R7", "done longer than one cycle", geom_valid_o, 0);
                done_prev = geom_valid_o;
                if (geom_valid_o) begin
                    check(!busy_o, "R7 R11", "busy in done cycle", busy_o, 0);
                    check(q_h.size() == 0, "R1", "seeks left at done", q_h.size(), 0);
                    check(geom_heads_o == 5'(exp_h), "R7", "head count", geom_heads_o, exp_h);
                    check(geom_cyls_o == 11'(exp_c), "R7", "cylinder count", geom_cyls_o, exp_c);
                    check(geom_sects_o == 7'(exp_s), "R7", "sector count", geom_sects_o, exp_s);
                    got_done = 1'b1;
                end
            end
        end
    end

    task automatic run_probe(input int drv, input int h, input int c, input int s,
                             input int lat, input bit intr);
        int n;
        build_expect(h, c, s);
        drv_h = h; drv_c = c; drv_s = s;
        lat_g = lat;
        exp_drive = drv;
        seek_idx = 0;
        got_done = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        drive_i = 3'(drv);
        @(negedge clk);
        start_i = 1'b0;
        drive_i = 3'(drv ^ 5);
        check(busy_o, "R11", "busy after start", busy_o, 1);
        if (intr) begin
            repeat (7) @(negedge clk);
            start_i = 1'b1;
            drive_i = 3'(drv ^ 3);
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o, "R9", "busy across ignored start", busy_o, 1);
        end
        n = 0;
        while (!got_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(got_done, "R7", "geometry strobe seen", got_done, 1);
        repeat (12) @(negedge clk);
        check(!busy_o, "R9", "idle after run", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o, "R12", "busy after reset", busy_o, 0);
        check(!seek_req_o, "R12", "request after reset", seek_req_o, 0);
        check(!geom_valid_o, "R12", "strobe after reset", geom_valid_o, 0);

        run_probe(1, 4, 615, 17, 0, 1'b0);   // typical drive, mixed outcomes
        run_probe(7, 16, 1024, 64, 2, 1'b0); // all seeks pass: top of every range
        run_probe(0, 1, 1, 1, 1, 1'b0);      // all seeks fail: bottom of every range
        run_probe(2, 5, 300, 33, 3, 1'b1);   // start while busy is ignored
        run_probe(4, 9, 1000, 2, 0, 1'b0);   // odd values, back-to-back run

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule